// File: doc/BRIEF.md
# Serial Memory Read Front-End

This block is the slave side of a serial peripheral link for a small byte-wide nonvolatile memory of 1024 locations. It watches chip select, the serial clock and the serial data input, assembles one-byte commands, decodes them, collects a two-byte address, and streams stored bytes back on the serial output. A read keeps going for as long as the host keeps clocking: the address steps up after every byte and folds back to zero past the top location. The storage is modelled as a synchronous register array inside the block. A write port on that array serves the companion programming logic, and a bench can use it to preload contents.

The serial pins are sampled by a faster system clock. The block finds the serial clock edges itself and assumes its inputs already belong to that clock domain. Enable-latch handling, sector programming and nonvolatile status timing sit in companion blocks. This block only emits one-cycle request pulses to them, with the decoded bytes and addresses attached. It also reads back their status byte and busy flag during a status read.

Top module: `spi_rd_front`

## Requirements
- R1: Until chip select has been seen going from high to low once after reset, serial clock edges cause no response: `so_oe_o` stays 0 and no request pulse is produced. Directly after reset `so_oe_o` and `so_o` are 0.
- R2: Command bits are taken from `si_i` on rising serial clock edges, most significant bit first. Command 0x06 gives one `wel_set_o` pulse and command 0x04 gives one `wel_clr_o` pulse. At most one request output is high in any cycle.
- R3: Command 0x03 followed by a 16-bit address selects location address[9:0]; the upper six address bits are ignored. The stored byte is then shifted out most significant bit first. The first bit appears after the falling edge that ends the 24th input bit, and each later bit appears after the next falling edge.
- R4: After every byte sent, the read location steps up by one; location 0x3FF is followed by 0x000.
- R5: `so_oe_o` drops to 0 in the clock cycle after chip select is sampled high. `so_o` reads 0 whenever `so_oe_o` is 0.
- R6: Raising chip select discards any partly received command. The next selection starts decoding from its first bit.
- R7: A command byte outside the six listed values makes the block ignore the rest of the selection: no output enable and no request pulses.
- R8: Command 0x05 shifts out `status_i` most significant bit first and repeats it every 8 bits. While `busy_i` is 1 the output bit reads 1, but the bit pointer still advances with every falling edge.
- R9: Command 0x01 produces, for every complete byte that follows it, one `stat_wr_o` pulse with that byte on `stat_data_o`.
- R10: Command 0x02 followed by a 16-bit address produces, for every complete data byte, one `prog_wr_o` pulse. `prog_data_o` carries the byte and `prog_addr_o` carries address[9:0] plus the byte's index, wrapping in 10 bits.
- R11: The serial clock may stop for any number of cycles and resume without the block losing its bit position.
- R12: `so_oe_o` rises only on a falling serial clock edge in a data or status output phase. It stays 0 during the command and address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out, 0 when not enabled |
| so_oe_o | output | 1 | Output enable for the serial data pad |
| status_i | input | 8 | Status byte from the companion status logic |
| busy_i | input | 1 | Nonvolatile write in progress |
| wel_set_o | output | 1 | Pulse: set-write-enable command decoded |
| wel_clr_o | output | 1 | Pulse: clear-write-enable command decoded |
| stat_wr_o | output | 1 | Pulse: status byte received |
| stat_data_o | output | 8 | Received status byte |
| prog_wr_o | output | 1 | Pulse: program data byte received |
| prog_addr_o | output | 10 | Target location of the program byte |
| prog_data_o | output | 8 | Program data byte |
| mem_we_i | input | 1 | Array write strobe |
| mem_waddr_i | input | 10 | Array write location |
| mem_wdata_i | input | 8 | Array write data |

## Verification
The bound checker watches several rules on every cycle. There is no output or request before the first chip-select fall, and the enable drops once chip select is high. Request pulses never overlap, each one follows a rising serial clock edge inside a selection, and the output enable only switches on after a falling edge. Only the bench's scenarios can show that values are correct. These cover the byte returned for a given address, the address wrap at the top of the array, the status repetition and busy override, discarding a partial command, ignoring an unknown command, and the bytes and addresses carried on the program and status-write requests.

// File: rtl/spi_rd_pkg.sv
// Shared constants and types of the serial memory read front-end.
// Assumes: command codes are 8 bits and travel most significant bit first.
package spi_rd_pkg;

    localparam logic [7:0] OPC_WEL_SET = 8'h06;
    localparam logic [7:0] OPC_WEL_CLR = 8'h04;
    localparam logic [7:0] OPC_STAT_WR = 8'h01;
    localparam logic [7:0] OPC_STAT_RD = 8'h05;
    localparam logic [7:0] OPC_PROG    = 8'h02;
    localparam logic [7:0] OPC_READ    = 8'h03;

    // Phase of the current selection.
    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_RDATA,
        PH_RSTAT,
        PH_WSTAT,
        PH_PDATA,
        PH_SKIP
    } phase_t;

    // What the output shifter presents on the serial output.
    typedef enum logic [1:0] {
        TX_OFF,
        TX_DATA,
        TX_STAT
    } txmode_t;

endpackage

// File: rtl/spi_rd_edges.sv
// Serial pin edge finder.
// Finds rising and falling serial clock edges in the system clock domain
// and qualifies them with chip select. It also holds off all activity
// until chip select has fallen once after reset.
// Assumes: cs_n_i and sck_i are already synchronous to clk, and each
// serial clock level lasts at least one clk cycle.
module spi_rd_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    output logic sel_o,
    output logic sck_rise_o,
    output logic sck_fall_o
);

    logic sck_q;
    logic cs_q;
    logic armed_q;
    logic cs_fall;

    // Previous samples of the pins, plus the armed flag set by the first select.
    // cs_q resets to 0 so a chip select held low through reset is not a fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            sck_q <= sck_i;
            cs_q  <= cs_n_i;
            if (cs_fall) begin
                armed_q <= 1'b1;
            end
        end
    end

    // Edge and selection qualifiers.
    always_comb begin
        cs_fall    = cs_q & ~cs_n_i;
        sel_o      = ~cs_n_i & (armed_q | cs_fall);
        sck_rise_o = sel_o & sck_i & ~sck_q;
        sck_fall_o = sel_o & ~sck_i & sck_q;
    end

endmodule

// File: rtl/spi_rd_mem.sv
// Synchronous byte array standing in for the nonvolatile cells.
// It has one write port for the companion programming logic and one
// registered read port.
// Assumes: a read and a write to the same location in one cycle returns old data.
module spi_rd_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Array write; the cells carry no reset.
    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (re_i) begin
            rdata_o <= cells[raddr_i];
        end
    end

endmodule

// File: rtl/spi_rd_cmd.sv
// Command engine: shifts in bits on rising serial clock edges, decodes
// the command byte, gathers the address and tracks the current location.
// It issues array reads and companion request pulses.
// Assumes: rise_i and tx_load_i never occur in the same cycle, and
// sel_i low means deselected, which returns the engine to its first bit.
module spi_rd_cmd
    import spi_rd_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int ABUS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              rise_i,
    input  logic              si_i,
    input  logic              tx_load_i,
    output txmode_t           mode_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wel_set_o,
    output logic              wel_clr_o,
    output logic              stat_wr_o,
    output logic [7:0]        stat_data_o,
    output logic              prog_wr_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [7:0]        prog_data_o
);

    localparam int CNT_W = $clog2(ABUS_W);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ABUS_W - 1);

    phase_t            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ABUS_W-1:0] sh_q;
    logic [ADDR_W-1:0] cur_q;
    logic              is_read_q;

    logic [ABUS_W-1:0] shifted;
    logic [7:0]        byte_now;
    logic              addr_last;

    // Next shift value and completion flags.
    always_comb begin
        shifted   = {sh_q[ABUS_W-2:0], si_i};
        byte_now  = shifted[7:0];
        addr_last = rise_i && (phase_q == PH_ADDR) && (cnt_q == ADDR_END);
    end

    // Phase, counter, shift and location registers plus request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_OPC;
            cnt_q       <= '0;
            sh_q        <= '0;
            cur_q       <= '0;
            is_read_q   <= 1'b0;
            wel_set_o   <= 1'b0;
            wel_clr_o   <= 1'b0;
            stat_wr_o   <= 1'b0;
            stat_data_o <= '0;
            prog_wr_o   <= 1'b0;
            prog_addr_o <= '0;
            prog_data_o <= '0;
        end else begin
            wel_set_o <= 1'b0;
            wel_clr_o <= 1'b0;
            stat_wr_o <= 1'b0;
            prog_wr_o <= 1'b0;
            if (!sel_i) begin
                phase_q <= PH_OPC;
                cnt_q   <= '0;
                sh_q    <= '0;
            end else if (rise_i) begin
                unique case (phase_q)
                    PH_OPC: begin
                        sh_q  <= shifted;
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == BYTE_END) begin
                            cnt_q <= '0;
                            unique case (byte_now)
                                OPC_READ: begin
                                    phase_q   <= PH_ADDR;
                                    is_read_q <= 1'b1;
                                end
                                OPC_PROG: begin
                                    phase_q   <= PH_ADDR;
                                    is_read_q <= 1'b0;
                                end
                                OPC_STAT_RD: phase_q <= PH_RSTAT;
                                OPC_STAT_WR: phase_q <= PH_WSTAT;
                                OPC_WEL_SET: begin
                                    wel_set_o <= 1'b1;
                                    phase_q   <= PH_SKIP;
                                end
                                OPC_WEL_CLR: begin
                                    wel_clr_o <= 1'b1;
                                    phase_q   <= PH_SKIP;
                                end
                                default: phase_q <= PH_SKIP;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        sh_q  <= shifted;
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == ADDR_END) begin
                            cnt_q   <= '0;
                            cur_q   <= shifted[ADDR_W-1:0];
                            phase_q <= is_read_q ? PH_RDATA : PH_PDATA;
                        end
                    end
                    PH_WSTAT: begin
                        sh_q  <= shifted;
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == BYTE_END) begin
                            cnt_q       <= '0;
                            stat_wr_o   <= 1'b1;
                            stat_data_o <= byte_now;
                        end
                    end
                    PH_PDATA: begin
                        sh_q  <= shifted;
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == BYTE_END) begin
                            cnt_q       <= '0;
                            prog_wr_o   <= 1'b1;
                            prog_addr_o <= cur_q;
                            prog_data_o <= byte_now;
                            cur_q       <= cur_q + ADDR_W'(1);
                        end
                    end
                    default: ;
                endcase
            end else if (tx_load_i && phase_q == PH_RDATA) begin
                cur_q <= cur_q + ADDR_W'(1);
            end
        end
    end

    // Array read requests: the first byte when the address completes,
    // then the next byte each time one is handed to the shifter.
    always_comb begin
        rd_en_o   = 1'b0;
        rd_addr_o = cur_q + ADDR_W'(1);
        if (addr_last && is_read_q) begin
            rd_en_o   = 1'b1;
            rd_addr_o = shifted[ADDR_W-1:0];
        end else if (sel_i && tx_load_i && phase_q == PH_RDATA) begin
            rd_en_o = 1'b1;
        end
    end

    // Output shifter mode follows the phase.
    always_comb begin
        unique case (phase_q)
            PH_RDATA: mode_o = TX_DATA;
            PH_RSTAT: mode_o = TX_STAT;
            default:  mode_o = TX_OFF;
        endcase
    end

endmodule

// File: rtl/spi_rd_tx.sv
// Output shifter: on every falling serial clock edge of an output phase it
// presents the next bit, either from the prefetched array byte or from the
// status byte (all ones while busy). It also owns the pad output enable.
// Assumes: the prefetched byte is valid by the first falling edge of a data phase.
module spi_rd_tx
    import spi_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic       fall_i,
    input  txmode_t    mode_i,
    input  logic [7:0] rd_data_i,
    input  logic [7:0] status_i,
    input  logic       busy_i,
    output logic       load_o,
    output logic       so_o,
    output logic       oe_o
);

    logic [7:0] sh_q;
    logic [2:0] pos_q;
    logic       oe_q;
    logic       wrap;

    // A new byte starts on the first falling edge or after the eighth bit.
    always_comb begin
        wrap   = !oe_q || (pos_q == 3'd7);
        load_o = sel_i && fall_i && (mode_i == TX_DATA) && wrap;
    end

    // Shift register, bit position and output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            pos_q <= '0;
            oe_q  <= 1'b0;
        end else if (!sel_i || mode_i == TX_OFF) begin
            pos_q <= '0;
            oe_q  <= 1'b0;
        end else if (fall_i) begin
            oe_q <= 1'b1;
            if (wrap) begin
                pos_q <= '0;
                sh_q  <= rd_data_i;
            end else begin
                pos_q <= pos_q + 3'd1;
                sh_q  <= {sh_q[6:0], 1'b0};
            end
        end
    end

    // Serial output bit selection.
    always_comb begin
        oe_o = oe_q;
        unique case (mode_i)
            TX_DATA: so_o = oe_q & sh_q[7];
            TX_STAT: so_o = oe_q & (busy_i | status_i[3'd7 - pos_q]);
            default: so_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_rd_front.sv
// Top of the serial memory read front-end. It joins the edge finder, the
// command engine, the output shifter and the byte array.
// Assumes: pins are synchronous to clk; the pad tri-states on so_oe_o low.
module spi_rd_front
    import spi_rd_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int ABUS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              si_i,
    output logic              so_o,
    output logic              so_oe_o,
    input  logic [7:0]        status_i,
    input  logic              busy_i,
    output logic              wel_set_o,
    output logic              wel_clr_o,
    output logic              stat_wr_o,
    output logic [7:0]        stat_data_o,
    output logic              prog_wr_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [7:0]        prog_data_o,
    input  logic              mem_we_i,
    input  logic [ADDR_W-1:0] mem_waddr_i,
    input  logic [7:0]        mem_wdata_i
);

    logic              sel;
    logic              rise;
    logic              fall;
    logic              tx_load;
    txmode_t           mode;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;

    spi_rd_edges edges_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n_i),
        .sck_i      (sck_i),
        .sel_o      (sel),
        .sck_rise_o (rise),
        .sck_fall_o (fall)
    );

    spi_rd_cmd #(
        .ADDR_W (ADDR_W),
        .ABUS_W (ABUS_W)
    ) cmd_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel),
        .rise_i      (rise),
        .si_i        (si_i),
        .tx_load_i   (tx_load),
        .mode_o      (mode),
        .rd_en_o     (rd_en),
        .rd_addr_o   (rd_addr),
        .wel_set_o   (wel_set_o),
        .wel_clr_o   (wel_clr_o),
        .stat_wr_o   (stat_wr_o),
        .stat_data_o (stat_data_o),
        .prog_wr_o   (prog_wr_o),
        .prog_addr_o (prog_addr_o),
        .prog_data_o (prog_data_o)
    );

    spi_rd_tx tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel),
        .fall_i    (fall),
        .mode_i    (mode),
        .rd_data_i (rd_data),
        .status_i  (status_i),
        .busy_i    (busy_i),
        .load_o    (tx_load),
        .so_o      (so_o),
        .oe_o      (so_oe_o)
    );

    spi_rd_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we_i),
        .waddr_i (mem_waddr_i),
        .wdata_i (mem_wdata_i),
        .re_i    (rd_en),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

endmodule

// File: rtl/spi_rd_front_chk.sv
// Port-level rules of spi_rd_front, checked on every clock; bound to the top.
// Assumes: reset is synchronous and active low.
module spi_rd_front_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_i,
    input logic sck_i,
    input logic so_oe_o,
    input logic wel_set_o,
    input logic wel_clr_o,
    input logic stat_wr_o,
    input logic prog_wr_o
);

    logic cs_prev_q;
    logic seen_q;
    logic any_req;

    // Own record of whether chip select has fallen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q <= 1'b0;
            seen_q    <= 1'b0;
        end else begin
            cs_prev_q <= cs_n_i;
            if (cs_prev_q && !cs_n_i) begin
                seen_q <= 1'b1;
            end
        end
    end

    // Any request pulse.
    always_comb begin
        any_req = wel_set_o | wel_clr_o | stat_wr_o | prog_wr_o;
    end

    assert_quiet_until_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (!so_oe_o && !any_req));

    assert_single_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wel_set_o, wel_clr_o, stat_wr_o, prog_wr_o}));

    assert_deselect_drops_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> !so_oe_o);

    // R9 and R10: requests only follow a rising serial clock edge while selected.
    assert_request_after_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> ($past(sck_i) && !$past(sck_i, 2) && !$past(cs_n_i)));

    assert_oe_on_falling_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe_o) |-> (!$past(sck_i) && $past(sck_i, 2)));

endmodule

bind spi_rd_front spi_rd_front_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n_i),
    .sck_i     (sck_i),
    .so_oe_o   (so_oe_o),
    .wel_set_o (wel_set_o),
    .wel_clr_o (wel_clr_o),
    .stat_wr_o (stat_wr_o),
    .prog_wr_o (prog_wr_o)
);

// File: tb/spi_rd_front_tb_top.sv
// Directed bench for spi_rd_front: one task per scenario, each checking itself.
module spi_rd_front_tb_top;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       so;
    logic       so_oe;
    logic [7:0] status = 8'h00;
    logic       busy = 1'b0;
    logic       wel_set, wel_clr, stat_wr, prog_wr;
    logic [7:0] stat_data, prog_data;
    logic [9:0] prog_addr;
    logic       mem_we = 1'b0;
    logic [9:0] mem_waddr = '0;
    logic [7:0] mem_wdata = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int n_set = 0, n_clr = 0, n_swr = 0, n_pwr = 0;
    logic [7:0] stat_log [8];
    logic [7:0] pdat_log [8];
    logic [9:0] padr_log [8];

    always #4 clk = ~clk;

    spi_rd_front dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (cs_n),
        .sck_i       (sck),
        .si_i        (si),
        .so_o        (so),
        .so_oe_o     (so_oe),
        .status_i    (status),
        .busy_i      (busy),
        .wel_set_o   (wel_set),
        .wel_clr_o   (wel_clr),
        .stat_wr_o   (stat_wr),
        .stat_data_o (stat_data),
        .prog_wr_o   (prog_wr),
        .prog_addr_o (prog_addr),
        .prog_data_o (prog_data),
        .mem_we_i    (mem_we),
        .mem_waddr_i (mem_waddr),
        .mem_wdata_i (mem_wdata)
    );

    // Request monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (wel_set) n_set++;
        if (wel_clr) n_clr++;
        if (stat_wr) begin
            stat_log[n_swr % 8] = stat_data;
            n_swr++;
        end
        if (prog_wr) begin
            pdat_log[n_pwr % 8] = prog_data;
            padr_log[n_pwr % 8] = prog_addr;
            n_pwr++;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + (a >> 8) * 91 + 11);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One serial bit: SO is sampled late in the low half, just before the rise.
    task automatic bit_xfer(input logic b, output logic so_s, output logic oe_s);
        si = b;
        repeat (HALF) @(negedge clk);
        so_s = so;
        oe_s = so_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic byte_xfer(input logic [7:0] tx, output logic [7:0] rx,
                             output logic oe_all, output logic oe_any);
        logic s, o;
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(tx[i], s, o);
            rx[i] = s;
            oe_all &= o;
            oe_any |= o;
        end
    endtask

    task automatic select();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic deselect(input string req);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check(req, "oe after deselect", so_oe, 1'b0);
        check(req, "so after deselect", so, 1'b0);
        repeat (HALF) @(negedge clk);
    endtask

    task automatic t_reset_and_unarmed();
        logic [7:0] rx;
        logic oa, on;
        check("R1", "oe at reset", so_oe, 1'b0);
        check("R1", "so at reset", so, 1'b0);
        byte_xfer(8'h06, rx, oa, on);
        byte_xfer(8'h05, rx, oa, on);
        byte_xfer(8'h00, rx, oa, on);
        repeat (2) @(negedge clk);
        check("R1", "no set pulse before first select", n_set, 0);
        check("R1", "no output before first select", on, 1'b0);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic t_enable_cmds();
        logic [7:0] rx;
        logic oa, on;
        int s0, c0;
        s0 = n_set;
        c0 = n_clr;
        select();
        byte_xfer(8'h06, rx, oa, on);
        deselect("R2");
        check("R2", "set pulse count", n_set - s0, 1);
        check("R2", "no clear pulse", n_clr - c0, 0);
        select();
        byte_xfer(8'h04, rx, oa, on);
        deselect("R2");
        check("R2", "clear pulse count", n_clr - c0, 1);
        check("R2", "set count unchanged", n_set - s0, 1);
    endtask

    task automatic t_read(input string req, input logic [15:0] addr, input int nbytes,
                          input int pause);
        logic [7:0] rx;
        logic oa, on;
        select();
        byte_xfer(8'h03, rx, oa, on);
        check("R12", "oe during command", on, 1'b0);
        byte_xfer(addr[15:8], rx, oa, on);
        check("R12", "oe during address high", on, 1'b0);
        if (pause > 0) repeat (pause) @(negedge clk);
        byte_xfer(addr[7:0], rx, oa, on);
        check("R12", "oe during address low", on, 1'b0);
        for (int k = 0; k < nbytes; k++) begin
            byte_xfer(8'h00, rx, oa, on);
            check(req, $sformatf("byte %0d", k), rx, pat((int'(addr[9:0]) + k) % 1024));
            check("R3", $sformatf("oe through byte %0d", k), oa, 1'b1);
        end
        deselect("R5");
    endtask

    task automatic t_partial_discard();
        logic s, o;
        logic [7:0] rx;
        logic oa, on;
        int s0;
        s0 = n_set;
        select();
        for (int i = 0; i < 5; i++) bit_xfer(1'b0, s, o);
        deselect("R6");
        select();
        byte_xfer(8'h06, rx, oa, on);
        deselect("R6");
        check("R6", "fresh command after partial", n_set - s0, 1);
    endtask

    task automatic t_unknown();
        logic [7:0] rx;
        logic oa, on;
        logic seen;
        int tot0;
        tot0 = n_set + n_clr + n_swr + n_pwr;
        seen = 1'b0;
        select();
        byte_xfer(8'hA5, rx, oa, on);
        seen |= on;
        byte_xfer(8'h03, rx, oa, on);
        seen |= on;
        byte_xfer(8'h06, rx, oa, on);
        seen |= on;
        byte_xfer(8'h01, rx, oa, on);
        seen |= on;
        byte_xfer(8'h00, rx, oa, on);
        seen |= on;
        check("R7", "so after unknown command", rx, 8'h00);
        deselect("R7");
        check("R7", "oe never set", seen, 1'b0);
        check("R7", "no requests", n_set + n_clr + n_swr + n_pwr - tot0, 0);
    endtask

    task automatic t_status_read();
        logic [7:0] rx;
        logic oa, on;
        status = 8'hB3;
        busy = 1'b0;
        select();
        byte_xfer(8'h05, rx, oa, on);
        check("R12", "oe during status command", on, 1'b0);
        byte_xfer(8'h00, rx, oa, on);
        check("R8", "status byte", rx, 8'hB3);
        byte_xfer(8'h00, rx, oa, on);
        check("R8", "status repeats", rx, 8'hB3);
        busy = 1'b1;
        byte_xfer(8'h00, rx, oa, on);
        check("R8", "busy reads ones", rx, 8'hFF);
        busy = 1'b0;
        byte_xfer(8'h00, rx, oa, on);
        check("R8", "pointer kept through busy", rx, 8'hB3);
        deselect("R8");
    endtask

    task automatic t_status_write();
        logic [7:0] rx;
        logic oa, on;
        int w0;
        w0 = n_swr;
        select();
        byte_xfer(8'h01, rx, oa, on);
        byte_xfer(8'h5A, rx, oa, on);
        byte_xfer(8'h07, rx, oa, on);
        deselect("R9");
        check("R9", "status write count", n_swr - w0, 2);
        check("R9", "first status byte", stat_log[w0 % 8], 8'h5A);
        check("R9", "second status byte", stat_log[(w0 + 1) % 8], 8'h07);
    endtask

    task automatic t_program();
        logic [7:0] rx;
        logic oa, on;
        int p0;
        p0 = n_pwr;
        select();
        byte_xfer(8'h02, rx, oa, on);
        byte_xfer(8'hFF, rx, oa, on);
        byte_xfer(8'hFF, rx, oa, on);
        byte_xfer(8'h11, rx, oa, on);
        byte_xfer(8'h22, rx, oa, on);
        check("R12", "oe during program", on, 1'b0);
        deselect("R10");
        check("R10", "program byte count", n_pwr - p0, 2);
        check("R10", "first address", padr_log[p0 % 8], 10'h3FF);
        check("R10", "first data", pdat_log[p0 % 8], 8'h11);
        check("R10", "second address wraps", padr_log[(p0 + 1) % 8], 10'h000);
        check("R10", "second data", pdat_log[(p0 + 1) % 8], 8'h22);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_unarmed();
        for (int a = 0; a < 1024; a++) begin
            mem_we = 1'b1;
            mem_waddr = 10'(a);
            mem_wdata = pat(a);
            @(negedge clk);
        end
        mem_we = 1'b0;
        @(negedge clk);
        t_enable_cmds();
        t_read("R3", 16'hFD23, 3, 0);
        t_read("R4", 16'h03FE, 4, 0);
        t_read("R11", 16'h0042, 2, 60);
        t_partial_discard();
        t_unknown();
        t_status_read();
        t_status_write();
        t_program();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule